// File: doc/BRIEF.md
# Link Deskew Pattern Sequencer

This block sits in front of the serializer of a multi-lane, source-synchronous transmitter and decides, symbol by symbol, what goes out on the forwarded-clock lane and on each data lane. In ordinary traffic it registers the parallel user word and places one 7-bit slice of it on each data lane. The clock lane carries an alternating pair of 7-bit clock shapes.

When balance mode is enabled and the active-low training request is held, the block stops taking in user data. Every lane then carries fixed 7-bit calibration symbols, so that a far-end receiver can tune its per-lane sampling strobes. The block also counts how many cycles the request has been held. Once the minimum training length has been reached, it raises a status output that stays high while the request is held.

Top module: `deskew_seq`

## Requirements
- R1: While rst_n is low, clk_sym is 7'b1111000, every lane_sym bit is 0, and trained is 0.
- R2: Outside training, each clock edge registers user_word, so lane k of lane_sym shows bits [7k+6:7k] of the word sampled at that edge (bit 6 of a symbol is sent first).
- R3: Outside training, clk_sym alternates every cycle between 7'b1111000 and 7'b1110000. The first edge after reset gives 7'b1110000.
- R4: Training is in effect when bal_en is 1 and deskew_n is 0 at an edge. clk_sym then alternates between 7'b1111100 and 7'b1100000, and the first training edge after a non-training edge always gives 7'b1111100.
- R5: During training, every data lane carries 7'b1111000 on the cycles where clk_sym is 7'b1111100, and 7'b1110000 on the cycles where clk_sym is 7'b1100000.
- R6: During training, user_word has no effect on lane_sym.
- R7: On the first edge at which training is no longer in effect, lane_sym shows the user_word sampled at that same edge.
- R8: While bal_en is 0, deskew_n has no effect: the outputs follow R2 and R3, and trained stays 0.
- R9: trained rises at the TRAIN_MIN-th consecutive training edge (default 4096) and is 0 before that edge.
- R10: The hold count saturates, so trained stays 1 for as long as training continues. The first non-training edge clears the count and drops trained, and a later training run must again last TRAIN_MIN edges before trained rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bal_en | input | 1 | Balance mode enable; training requests are honoured only when 1 |
| deskew_n | input | 1 | Active-low training request |
| user_word | input | LANES*7 | Parallel user data, 7 bits per lane |
| clk_sym | output | 7 | 7-bit symbol for the forwarded-clock lane |
| lane_sym | output | LANES*7 | 7-bit symbols for the data lanes, lane k at [7k+6:7k] |
| trained | output | 1 | Minimum training length has been met while the request is still held |

## Verification
Random user words are first driven with balance mode on and the request released, which separates correct per-lane slicing and the one-cycle registering from byte or lane swaps. The request is then held low with balance mode off. This shows whether the request gate depends on the mode flag.

Short training bursts carrying changing user words show two things: that calibration symbols fully replace the data, and that the phase restarts on the long form at entry rather than continuing from the normal clock shape. A run longer than the minimum length, followed by a release and a shorter retry, separates an early or late status edge, a counter that wraps instead of saturating, and a count that is not cleared on release.

// File: rtl/deskew_seq_pkg.sv
package deskew_seq_pkg;
   localparam int SYM_W = 7;
   typedef logic [SYM_W-1:0] sym_t;

   localparam sym_t CLK_NORM_LONG  = 7'b1111000;
   localparam sym_t CLK_NORM_SHORT = 7'b1110000;
   localparam sym_t CLK_CAL_LONG   = 7'b1111100;
   localparam sym_t CLK_CAL_SHORT  = 7'b1100000;
   localparam sym_t LANE_CAL_LONG  = 7'b1111000;
   localparam sym_t LANE_CAL_SHORT = 7'b1110000;

   function automatic sym_t pick_sym(input logic use_short, input sym_t long_s, input sym_t short_s);
      return use_short ? short_s : long_s;
   endfunction
endpackage

// File: rtl/deskew_seq_phase.sv
module deskew_seq_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic train,
   output logic sel_short
);
   logic ph_q;
   logic train_q;

   // entry into training always restarts on the long form
   always_comb begin
      if (train && !train_q) sel_short = 1'b0;
      else                   sel_short = ph_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= 1'b1;
         train_q <= 1'b0;
      end else begin
         ph_q    <= ~sel_short;
         train_q <= train;
      end
   end
endmodule

// File: rtl/deskew_seq_holdcnt.sv
module deskew_seq_holdcnt #(
   parameter int TRAIN_MIN = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic train,
   output logic trained
);
   localparam int CNT_W = $clog2(TRAIN_MIN + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TRAIN_MIN);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (!train)              cnt_d = '0;
      else if (cnt_q == LIMIT) cnt_d = cnt_q;
      else                     cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         trained <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         trained <= train && (cnt_d == LIMIT);
      end
   end
endmodule

// File: rtl/deskew_seq_lanes.sv
module deskew_seq_lanes
   import deskew_seq_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   train,
   input  logic                   sel_short,
   input  logic [LANES*SYM_W-1:0] user_word,
   output logic [LANES*SYM_W-1:0] lane_sym
);
   sym_t cal_sym;
   assign cal_sym = pick_sym(sel_short, LANE_CAL_LONG, LANE_CAL_SHORT);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      sym_t lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     lane_q <= '0;
         else if (train) lane_q <= cal_sym;
         else            lane_q <= user_word[k*SYM_W +: SYM_W];
      end
      assign lane_sym[k*SYM_W +: SYM_W] = lane_q;
   end
endmodule

// File: rtl/deskew_seq.sv
module deskew_seq
   import deskew_seq_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int TRAIN_MIN = 4096
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bal_en,
   input  logic                   deskew_n,
   input  logic [LANES*SYM_W-1:0] user_word,
   output logic [SYM_W-1:0]       clk_sym,
   output logic [LANES*SYM_W-1:0] lane_sym,
   output logic                   trained
);
   if (LANES < 1) begin : g_bad_lanes
      $error("deskew_seq: LANES must be at least 1");
   end
   if (TRAIN_MIN < 2) begin : g_bad_min
      $error("deskew_seq: TRAIN_MIN must be at least 2");
   end

   logic train;
   logic sel_short;
   sym_t clk_d;

   assign train = bal_en && !deskew_n;

   deskew_seq_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .train     (train),
      .sel_short (sel_short)
   );

   deskew_seq_holdcnt #(.TRAIN_MIN(TRAIN_MIN)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .train   (train),
      .trained (trained)
   );

   deskew_seq_lanes #(.LANES(LANES)) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .train     (train),
      .sel_short (sel_short),
      .user_word (user_word),
      .lane_sym  (lane_sym)
   );

   always_comb begin
      if (train) clk_d = pick_sym(sel_short, CLK_CAL_LONG, CLK_CAL_SHORT);
      else       clk_d = pick_sym(sel_short, CLK_NORM_LONG, CLK_NORM_SHORT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_sym <= CLK_NORM_LONG;
      else        clk_sym <= clk_d;
   end
endmodule

// File: rtl/deskew_seq_chk.sv
module deskew_seq_chk #(
   parameter int LANES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bal_en,
   input logic               deskew_n,
   input logic [6:0]         clk_sym,
   input logic [LANES*7-1:0] lane_sym,
   input logic               trained
);
   logic t;
   assign t = bal_en && !deskew_n;

   p_cal_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      t |=> (lane_sym == {LANES{7'b1111000}} || lane_sym == {LANES{7'b1110000}}));

   p_cal_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (t && !$past(t) && $past(rst_n)) |=> clk_sym == 7'b1111100);

   p_cal_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (t && $past(t && rst_n)) |=> clk_sym != $past(clk_sym));

   p_bal_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bal_en |=> ((clk_sym == 7'b1111000 || clk_sym == 7'b1110000) && !trained));

   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !t |=> !trained);
endmodule

bind deskew_seq deskew_seq_chk #(.LANES(LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bal_en   (bal_en),
   .deskew_n (deskew_n),
   .clk_sym  (clk_sym),
   .lane_sym (lane_sym),
   .trained  (trained)
);

// File: tb/deskew_seq_bench.sv
`timescale 1ns/1ps
module deskew_seq_bench;
   localparam int LANES = 8;
   localparam int TMIN  = 4096;
   localparam int W     = LANES*7;

   logic clk = 0;
   logic rst_n = 0;
   logic bal_en = 1;
   logic deskew_n = 1;
   logic [W-1:0] user_word = '0;
   logic [6:0]   clk_sym;
   logic [W-1:0] lane_sym;
   logic         trained;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   deskew_seq #(.LANES(LANES), .TRAIN_MIN(TMIN)) u_deskew_seq (
      .clk(clk), .rst_n(rst_n), .bal_en(bal_en), .deskew_n(deskew_n),
      .user_word(user_word), .clk_sym(clk_sym), .lane_sym(lane_sym), .trained(trained)
   );

   // behavioural reference model
   int  m_short = 1;
   bit  m_prev  = 0;
   int  m_cnt   = 0;
   bit  m_train = 0;
   logic [6:0]   e_clk  = 7'b1111000;
   logic [W-1:0] e_lane = '0;
   bit           e_tr   = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_short = 1; m_prev = 0; m_cnt = 0; m_train = 0;
         e_clk = 7'b1111000; e_lane = '0; e_tr = 0;
      end else begin
         bit t;
         int s;
         t = bal_en && !deskew_n;
         s = (t && !m_prev) ? 0 : m_short;
         if (t) begin
            e_clk = (s != 0) ? 7'b1100000 : 7'b1111100;
            e_lane = '0;
            for (int k = 0; k < LANES; k++)
               e_lane[k*7 +: 7] = (s != 0) ? 7'b1110000 : 7'b1111000;
            m_cnt = (m_cnt < TMIN) ? m_cnt + 1 : m_cnt;
         end else begin
            e_clk  = (s != 0) ? 7'b1110000 : 7'b1111000;
            e_lane = user_word;
            m_cnt  = 0;
         end
         e_tr    = t && (m_cnt == TMIN);
         m_short = 1 - s;
         m_prev  = t;
         m_train = t;
      end
   end

   string tag = "R1";

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         string tc, tl;
         tc = (!rst_n) ? "R1" : (m_train ? "R4" : "R3");
         tl = (!rst_n) ? "R1" : (m_train ? "R5/R6" : "R2/R7");
         vectors++;
         if (clk_sym !== e_clk) begin
            miscompares++;
            $display("FAIL %s (%s) clk_sym actual=%b expected=%b", tc, tag, clk_sym, e_clk);
         end
         if (lane_sym !== e_lane) begin
            miscompares++;
            $display("FAIL %s (%s) lane_sym actual=%h expected=%h", tl, tag, lane_sym, e_lane);
         end
         if (trained !== e_tr) begin
            miscompares++;
            $display("FAIL R9/R10 (%s) trained actual=%b expected=%b", tag, trained, e_tr);
         end
      end
   end

   task automatic cycles(input int n, input bit bal, input bit req_n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bal_en = bal; deskew_n = req_n;
         user_word = {$urandom, $urandom};
      end
   endtask

   task automatic named_check(input string req, input logic [W:0] act, input logic [W:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s explicit actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      // R1: reset values
      tag = "R1";
      repeat (3) @(negedge clk);
      named_check("R1", {1'b0, 49'd0, clk_sym}, {1'b0, 49'd0, 7'b1111000});
      named_check("R1", {1'b0, lane_sym}, '0);
      rst_n = 1;
      // R2 R3: normal traffic
      tag = "R2/R3";
      cycles(20, 1, 1);
      // R8: request held with balance mode off
      tag = "R8";
      cycles(30, 0, 0);
      @(negedge clk); named_check("R8", {56'd0, trained}, '0);
      // R4 R5 R6: short training burst with changing words
      tag = "R4/R5/R6";
      cycles(9, 1, 0);
      @(negedge clk);
      named_check("R6", {1'b0, lane_sym}, {1'b0, {LANES{e_lane[6:0]}}});
      // R7: release
      tag = "R7";
      cycles(5, 1, 1);
      // R9 R10: long run, saturation
      tag = "R9";
      cycles(TMIN - 1, 1, 0);
      @(negedge clk); named_check("R9", {56'd0, trained}, '0);
      tag = "R10";
      cycles(40, 1, 0);
      @(negedge clk); named_check("R10", {56'd0, trained}, {56'd0, 1'b1});
      cycles(2, 1, 1);
      @(negedge clk); named_check("R10", {56'd0, trained}, '0);
      cycles(100, 1, 0);
      @(negedge clk); named_check("R10", {56'd0, trained}, '0);
      cycles(10, 1, 1);
      @(negedge clk);
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule